// File: doc/BRIEF.md
# Interrupt Status, Acknowledge and Enable Register Bank

This block gathers fourteen event sources of a display link controller into two
32-bit software-visible registers and one level interrupt line. Every source owns
three neighbouring bits in its register: a sticky status bit at position 3i, a
write-one-to-clear acknowledge bit at 3i+1 and an enable bit at 3i+2. A one-cycle
pulse on a source's event input latches its status bit. Software clears status
by writing ones to the acknowledge positions and unmasks sources through the
enable positions.

The first register (select 0) holds ten sources. In source order 0 to 9 they are:
hot-plug detect, sideband transfer done, wrong address, timeout, NACK-or-defer,
wrong data count, I2C NACK, I2C defer, PLL unlock and sideband error. The second
register (select 1) holds four sources. In source order 0 to 3 they are: ready for
video, idle patterns sent, frame end and CRC updated. Every write to a register
rewrites all of its enable bits, so a driver that only wants to acknowledge must
write back the enables it wants to keep. The register port is a plain
single-cycle interface and has no back-pressure. A write takes effect at the
clock edge where `wr_en` is high. A read is combinational from the current state.
No stream interface exists, so the block has no valid/ready pair.

Top module: `irqbank_top`

## Requirements
- R1: While `rst_n` is low, all status and enable bits clear and `irq` is low. After reset both registers read zero.
- R2: A high bit i on `evt_a` (or `evt_b`) at a clock edge sets status bit i of register 0 (or 1). The bit reads at position 3i from the next cycle on.
- R3: A status bit holds until a write to its own register carries a one at position 3i+1. A zero at that position leaves the bit unchanged.
- R4: Each write to a register loads every enable bit i of that register from write-data bit 3i+2. The other register is not touched, and its enables change only through writes to it.
- R5: When an event and an acknowledge for the same source arrive at the same edge, the status bit ends set.
- R6: `irq` is a register. After each edge it equals the OR, over all sources, of status AND enable as they were held before that edge.
- R7: `rd_data` shows the register picked by `reg_sel` (0 selects the ten-source register, 1 the four-source register). It has status at 3i, enable at 3i+2 and zero at every acknowledge position.
- R8: Writing zero to both registers masks every source. `irq` then falls while the status bits stay set.
- R9: Bits above the last source group (positions 30 and 31 of register 0, positions 12 to 31 of register 1) read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register select: 0 for the ten-source register, 1 for the four-source register |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 32 | Write data (status at 3i ignored, ack at 3i+1, enable at 3i+2) |
| rd_data | output | 32 | Combinational read of the selected register |
| evt_a | input | 10 | One-cycle event pulses for the first register's sources |
| evt_b | input | 4 | One-cycle event pulses for the second register's sources |
| irq | output | 1 | Registered level interrupt |

## Verification
The bench builds the block with its default parameters: ten and four sources in 32-bit words. These defaults leave unused tail bits in both registers, so the ignored-bit behaviour can be observed on both. Random events, writes and register selections run through a bench model. That model recomputes the packed read word and the delayed interrupt after every cycle. Directed cases then cover the same-edge event and acknowledge race, write-back of enables during an acknowledge, and the all-zero mask write.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;
  localparam int unsigned GRP_W  = 3;
  localparam int unsigned OFS_ST = 0;
  localparam int unsigned OFS_AK = 1;
  localparam int unsigned OFS_EN = 2;

  typedef enum logic {
    SEL_LINK = 1'b0,
    SEL_VID  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irqbank_cell.sv
module irqbank_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic wr_hit,
  input  logic ack,
  input  logic en_in,
  output logic stat_q,
  output logic en_q
);
  // The event term is ORed in last, so a pulse at the same edge as an ack wins.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      stat_q <= evt | (stat_q & ~(wr_hit & ack));
      if (wr_hit) en_q <= en_in;
    end
  end
endmodule

// File: rtl/irqbank_group.sv
module irqbank_group
  import irqbank_pkg::*;
#(
  parameter int unsigned N_SRC = 10,
  parameter int unsigned DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt,
  input  logic             wr_hit,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_word,
  output logic [N_SRC-1:0] stat,
  output logic [N_SRC-1:0] en,
  output logic             pend
);
  localparam int unsigned USED_W = GRP_W * N_SRC;

  function automatic logic [DW-1:0] ignored_bits();
    logic [DW-1:0] m;
    m = '1;
    for (int i = 0; i < int'(N_SRC); i++) begin
      m[GRP_W*i + OFS_AK] = 1'b0;
      m[GRP_W*i + OFS_EN] = 1'b0;
    end
    return m;
  endfunction

  localparam logic [DW-1:0] IGN_MASK = ignored_bits();

  logic unused_wr_bits;
  assign unused_wr_bits = ^(wr_data & IGN_MASK);

  for (genvar i = 0; i < int'(N_SRC); i++) begin : g_src
    irqbank_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt[i]),
      .wr_hit (wr_hit),
      .ack    (wr_data[GRP_W*i + OFS_AK]),
      .en_in  (wr_data[GRP_W*i + OFS_EN]),
      .stat_q (stat[i]),
      .en_q   (en[i])
    );
    assign rd_word[GRP_W*i + OFS_ST] = stat[i];
    assign rd_word[GRP_W*i + OFS_AK] = 1'b0;
    assign rd_word[GRP_W*i + OFS_EN] = en[i];
  end

  if (USED_W < DW) begin : g_tail
    assign rd_word[DW-1:USED_W] = '0;
  end

  assign pend = |(stat & en);
endmodule

// File: rtl/irqbank_top.sv
module irqbank_top
  import irqbank_pkg::*;
#(
  parameter int unsigned N_A = 10,
  parameter int unsigned N_B = 4,
  parameter int unsigned DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_sel,
  input  logic           wr_en,
  input  logic [DW-1:0]  wr_data,
  output logic [DW-1:0]  rd_data,
  input  logic [N_A-1:0] evt_a,
  input  logic [N_B-1:0] evt_b,
  output logic           irq
);
  logic [N_A-1:0] stat_a, en_a;
  logic [N_B-1:0] stat_b, en_b;
  logic [DW-1:0]  word_a, word_b;
  logic           pend_a, pend_b;
  logic           hit_a, hit_b;
  logic           irq_q;

  assign hit_a = wr_en && (reg_sel == SEL_LINK);
  assign hit_b = wr_en && (reg_sel == SEL_VID);

  irqbank_group #(.N_SRC(N_A), .DW(DW)) u_grp_a (
    .clk(clk), .rst_n(rst_n), .evt(evt_a), .wr_hit(hit_a), .wr_data(wr_data),
    .rd_word(word_a), .stat(stat_a), .en(en_a), .pend(pend_a)
  );

  irqbank_group #(.N_SRC(N_B), .DW(DW)) u_grp_b (
    .clk(clk), .rst_n(rst_n), .evt(evt_b), .wr_hit(hit_b), .wr_data(wr_data),
    .rd_word(word_b), .stat(stat_b), .en(en_b), .pend(pend_b)
  );

  assign rd_data = (reg_sel == SEL_VID) ? word_b : word_a;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pend_a | pend_b;
  end

  assign irq = irq_q;
endmodule

// File: rtl/irqbank_chk.sv
module irqbank_chk #(
  parameter int unsigned N_A = 10,
  parameter int unsigned N_B = 4,
  parameter int unsigned DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_sel,
  input logic           wr_en,
  input logic [DW-1:0]  wr_data,
  input logic [N_A-1:0] evt_a,
  input logic [N_B-1:0] evt_b,
  input logic [N_A-1:0] stat_a,
  input logic [N_A-1:0] en_a,
  input logic [N_B-1:0] stat_b,
  input logic [N_B-1:0] en_b,
  input logic           irq
);
  logic [N_A-1:0] ack_a, clr_a;
  for (genvar i = 0; i < int'(N_A); i++) begin : g_ack
    assign ack_a[i] = wr_data[3*i + 1];
  end
  assign clr_a = (wr_en && reg_sel == 1'b0) ? ack_a : '0;

  a_r2_event_sets_a: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_a) |=> ((stat_a & $past(evt_a)) == $past(evt_a)));

  a_r2_event_sets_b: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_b) |=> ((stat_b & $past(evt_b)) == $past(evt_b)));

  a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_a & ~evt_a)) |=> ((stat_a & $past(clr_a & ~evt_a)) == '0));

  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat_a) |=> ((stat_a & $past(stat_a & ~clr_a)) == $past(stat_a & ~clr_a)));

  a_r4_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> ($stable(en_a) && $stable(en_b)));

  a_r6_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq == $past((|(stat_a & en_a)) || (|(stat_b & en_b)))));
endmodule

bind irqbank_top irqbank_chk #(.N_A(N_A), .N_B(N_B), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
  .evt_a(evt_a), .evt_b(evt_b), .stat_a(stat_a), .en_a(en_a),
  .stat_b(stat_b), .en_b(en_b), .irq(irq)
);

// File: tb/test_irqbank_top.sv
`timescale 1ns/1ps
module test_irqbank_top;
  localparam int N_A = 10;
  localparam int N_B = 4;
  localparam int DW  = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_sel = 1'b0;
  logic           wr_en = 1'b0;
  logic [DW-1:0]  wr_data = '0;
  logic [N_A-1:0] evt_a = '0;
  logic [N_B-1:0] evt_b = '0;
  logic [DW-1:0]  rd_data;
  logic           irq;

  int n_vec = 0;
  int n_bad = 0;

  logic [N_A-1:0] m_sa = '0, m_ea = '0;
  logic [N_B-1:0] m_sb = '0, m_eb = '0;

  always #4 clk = ~clk;

  irqbank_top #(.N_A(N_A), .N_B(N_B), .DW(DW)) i_irqbank_top (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .evt_a(evt_a), .evt_b(evt_b),
    .irq(irq)
  );

  function automatic logic [N_A-1:0] field(input logic [DW-1:0] wd, input int ofs, input int n);
    logic [N_A-1:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = wd[3*i + ofs];
    return r;
  endfunction

  function automatic logic [DW-1:0] pack(input logic [N_A-1:0] s, input logic [N_A-1:0] e, input int n);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < n; i++) begin
      r[3*i]     = s[i];
      r[3*i + 2] = e[i];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic [N_A-1:0] ea, input logic [N_B-1:0] eb,
                       input logic we, input logic sel, input logic [DW-1:0] wd);
    logic           exp_irq;
    logic [N_A-1:0] clr_a;
    logic [N_B-1:0] clr_b;
    evt_a = ea; evt_b = eb; wr_en = we; reg_sel = sel; wr_data = wd;
    exp_irq = (|(m_sa & m_ea)) || (|(m_sb & m_eb));
    clr_a = (we && !sel) ? field(wd, 1, N_A) : '0;
    clr_b = (we && sel) ? N_B'(field(wd, 1, N_B)) : '0;
    m_sa = ea | (m_sa & ~clr_a);
    m_sb = eb | (m_sb & ~clr_b);
    if (we && !sel) m_ea = field(wd, 2, N_A);
    if (we && sel)  m_eb = N_B'(field(wd, 2, N_B));
    @(posedge clk);
    @(negedge clk);
    check("R6 irq", DW'(irq), DW'(exp_irq));
  endtask

  task automatic check_reads(input string req);
    evt_a = '0; evt_b = '0; wr_en = 1'b0;
    reg_sel = 1'b0; #1;
    check(req, rd_data, pack(m_sa, m_ea, N_A));
    reg_sel = 1'b1; #1;
    check(req, rd_data, pack({{(N_A-N_B){1'b0}}, m_sb}, {{(N_A-N_B){1'b0}}, m_eb}, N_B));
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C3A));
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 irq", DW'(irq), '0);
    check_reads("R1");
    rst_n = 1'b1;

    // R2: events latch, masked so no interrupt
    cycle(10'b10_0000_0001, 4'b0000, 1'b0, 1'b0, '0);
    check_reads("R2");
    cycle('0, 4'b0010, 1'b0, 1'b0, '0);
    check_reads("R2");
    cycle('0, '0, 1'b0, 1'b0, '0);
    check("R6 masked", DW'(irq), '0);

    // R4: enable source 9 of register 0, then interrupt follows
    cycle('0, '0, 1'b1, 1'b0, 32'h1 << 29);
    check_reads("R4");
    cycle('0, '0, 1'b0, 1'b0, '0);
    check("R6 unmasked", DW'(irq), 32'd1);

    // R5: ack and event together for source 9, enable written back
    cycle(10'b10_0000_0000, '0, 1'b1, 1'b0, (32'h1 << 28) | (32'h1 << 29));
    check_reads("R5");

    // R3: ack source 0 only
    cycle('0, '0, 1'b1, 1'b0, (32'h1 << 1) | (32'h1 << 29));
    check_reads("R3");

    // R4: enable source 1 of register 1, register 0 untouched
    cycle('0, '0, 1'b1, 1'b1, 32'h1 << 5);
    check_reads("R4");

    // R8: zero to both masks everything, status stays
    cycle('0, '0, 1'b1, 1'b0, '0);
    cycle('0, '0, 1'b1, 1'b1, '0);
    cycle('0, '0, 1'b0, 1'b0, '0);
    check("R8 irq", DW'(irq), '0);
    check_reads("R8");

    // R9: unused tail bits
    cycle('0, '0, 1'b1, 1'b0, 32'hC000_0000 | (32'h1 << 11));
    check_reads("R9");
    cycle('0, '0, 1'b1, 1'b1, 32'hFFFF_F000);
    check_reads("R9");

    // R3: all-ones write acks everything and enables all
    cycle(10'h3FF, 4'hF, 1'b0, 1'b0, '0);
    cycle('0, '0, 1'b1, 1'b0, 32'hFFFF_FFFF);
    check_reads("R3");

    // R7: random mix
    for (int k = 0; k < 3000; k++) begin
      logic [N_A-1:0] ea;
      logic [N_B-1:0] eb;
      ea = ($urandom % 4 == 0) ? N_A'($urandom) : '0;
      eb = ($urandom % 4 == 0) ? N_B'($urandom) : '0;
      cycle(ea, eb, ($urandom % 3 == 0), $urandom % 2, $urandom);
      check_reads("R7");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule